// File: doc/BRIEF.md
# UART Register-Access Control Bridge

This block is a slave on an asynchronous serial control line. A host sends short byte packets to it over one UART wire, and each packet reads or writes a small internal register file. The slave answers on its own transmit wire with an acknowledge byte, or with an acknowledge byte followed by the requested register contents. The bit period is set by a clock divider input, so one implementation can serve links anywhere from about 9.6 kbit/s to 1 Mbit/s.

A packet opens with a fixed sync byte. Next comes an address byte that holds a 7-bit device address and a read/write flag. Then come a starting register address and a byte count. A write packet ends with its data bytes. The byte count makes the register pointer step forward by one for each byte. A lock input makes every register read-only until the next reset. Host logic in the same clock domain can read any register through a separate combinational port.

Top module: `uart_reg_bridge`

## Requirements
- R1: Every byte on `tx_o` is framed as one low start bit, 8 data bits sent LSB first, one even-parity bit (the XOR of the data bits) and one high stop bit. Each bit lasts `bit_div_i` clock cycles, and the line rests high between frames. Received frames must have the same shape.
- R2: A packet is recognised only if its first byte is 0x79. Any byte that arrives while the slave waits for a packet and is not 0x79 is dropped, with no register change and no response.
- R3: The second byte carries the device address in bits 7:1 and the direction in bit 0 (1 = read, 0 = write). If bits 7:1 differ from `dev_addr_i`, the rest of the packet is consumed, but no register is written and nothing is transmitted.
- R4: A write packet is sync, address byte, register address, count, then data bytes. Data byte k goes to register (start + k) modulo NREGS, where start is the low log2(NREGS) bits of the register address byte. After the last data byte the slave transmits 0xC3.
- R5: A read packet is sync, address byte, register address, count. The slave transmits 0xC3, then the contents of the consecutive registers from the start address, wrapping modulo NREGS, one byte per count.
- R6: A count byte of 0 is handled as a count of 1.
- R7: A received byte with a parity error or a low stop bit ends the current packet. No later byte of that packet is written, and no acknowledge is sent.
- R8: Inside a packet, the receive line may stay idle for up to 16 bit times between frames. If it stays idle longer than that, the slave abandons the packet and waits for a new sync byte.
- R9: Once `cfg_block_i` has been high in any clock cycle, write packets still receive 0xC3 but change no register. This lasts until `rst_ni` is asserted.
- R10: After reset every register holds 0x00 and `tx_o` is high.
- R11: `reg_rdata_o` always shows the register selected by `reg_raddr_i`, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idle high |
| tx_o | output | 1 | Serial transmit line, idle high |
| bit_div_i | input | DIV_W | Clock cycles per bit (at least 4) |
| dev_addr_i | input | 7 | Device address this slave answers to |
| cfg_block_i | input | 1 | Sets the sticky write lock |
| reg_raddr_i | input | log2(NREGS) | Local register read address |
| reg_rdata_o | output | 8 | Local register read data |

## Verification
The assertions assume that `bit_div_i` is at least 4 and does not change while a frame is in flight. They also assume that the host does not start a new packet while the slave is still transmitting its response. The bench changes the divider only between packets, when both lines are idle. It waits out the full response before it sends the next packet, and its gaps between bytes stay a few cycles long except in the directed timeout cases.

// File: rtl/ubr_pkg.sv
`timescale 1ns/1ps
package ubr_pkg;
  localparam logic [7:0] SYNC_CODE = 8'h79;
  localparam logic [7:0] ACK_CODE  = 8'hC3;
  localparam int unsigned FRAME_BITS = 11;
  localparam int unsigned IDLE_SHIFT = 4;  // idle limit = 16 bit times
  typedef enum logic [2:0] {P_SYNC, P_DEV, P_REG, P_CNT, P_DATA, P_RESP} pstate_e;
endpackage

// File: rtl/ubr_rx.sv
`timescale 1ns/1ps
module ubr_rx #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic [DIV_W-1:0] bit_div_i,
  output logic             busy_o,
  output logic             valid_o,
  output logic [7:0]       data_o,
  output logic             err_o
);
  logic rx_meta_q, rx_s_q, rx_prev_q;
  logic busy_q, valid_q, err_q, par_q;
  logic [3:0] phase_q;
  logic [DIV_W-1:0] cnt_q;
  logic [7:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_meta_q <= 1'b1;
      rx_s_q    <= 1'b1;
      rx_prev_q <= 1'b1;
    end else begin
      rx_meta_q <= rx_i;
      rx_s_q    <= rx_meta_q;
      rx_prev_q <= rx_s_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      par_q   <= 1'b0;
      phase_q <= '0;
      cnt_q   <= '0;
      sh_q    <= '0;
    end else begin
      valid_q <= 1'b0;
      if (!busy_q) begin
        if (rx_prev_q && !rx_s_q) begin
          busy_q  <= 1'b1;
          phase_q <= '0;
          cnt_q   <= bit_div_i >> 1;  // land mid-bit
        end
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - DIV_W'(1);
      end else begin
        cnt_q <= bit_div_i - DIV_W'(1);
        case (phase_q)
          4'd0: begin
            if (rx_s_q) busy_q <= 1'b0;  // glitch, not a start bit
            else phase_q <= 4'd1;
          end
          4'd9: begin
            par_q   <= rx_s_q;
            phase_q <= 4'd10;
          end
          4'd10: begin
            busy_q  <= 1'b0;
            valid_q <= 1'b1;
            err_q   <= !rx_s_q || ((^sh_q) != par_q);
          end
          default: begin
            sh_q    <= {rx_s_q, sh_q[7:1]};
            phase_q <= phase_q + 4'd1;
          end
        endcase
      end
    end
  end

  assign busy_o  = busy_q;
  assign valid_o = valid_q;
  assign data_o  = sh_q;
  assign err_o   = err_q;

  AST_RX_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q); // R1
endmodule

// File: rtl/ubr_tx.sv
`timescale 1ns/1ps
module ubr_tx #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] bit_div_i,
  input  logic             valid_i,
  input  logic [7:0]       data_i,
  output logic             ready_o,
  output logic             tx_o
);
  import ubr_pkg::*;
  logic busy_q;
  logic [FRAME_BITS-1:0] frame_q;
  logic [3:0] bitn_q;
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      frame_q <= '1;
      bitn_q  <= '0;
      cnt_q   <= '0;
    end else if (!busy_q) begin
      if (valid_i) begin
        busy_q  <= 1'b1;
        frame_q <= {1'b1, ^data_i, data_i, 1'b0};
        bitn_q  <= '0;
        cnt_q   <= bit_div_i - DIV_W'(1);
      end
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - DIV_W'(1);
    end else begin
      cnt_q   <= bit_div_i - DIV_W'(1);
      frame_q <= {1'b1, frame_q[FRAME_BITS-1:1]};
      bitn_q  <= bitn_q + 4'd1;
      if (bitn_q == 4'(FRAME_BITS - 1)) busy_q <= 1'b0;
    end
  end

  assign ready_o = !busy_q;
  assign tx_o    = busy_q ? frame_q[0] : 1'b1;

  AST_TX_START_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !tx_o); // R1
endmodule

// File: rtl/ubr_regs.sv
`timescale 1ns/1ps
module ubr_regs #(
  parameter int unsigned NREGS = 16,
  parameter int unsigned AW    = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lock_set_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [7:0]    rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [7:0]    rdata_b_o
);
  logic [NREGS-1:0][7:0] regs_q;
  logic lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= 1'b0;
    else if (lock_set_i) lock_q <= 1'b1;
  end

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[g] <= '0;
      else if (we_i && !lock_q && waddr_i == AW'(g)) regs_q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q); // R9
  AST_LOCK_FREEZES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && we_i) |=> $stable(regs_q)); // R9
  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !lock_q) |=> regs_q[$past(waddr_i)] == $past(wdata_i)); // R4
endmodule

// File: rtl/ubr_parser.sv
`timescale 1ns/1ps
module ubr_parser #(
  parameter int unsigned AW    = 4,
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] bit_div_i,
  input  logic [6:0]       dev_addr_i,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_i,
  input  logic             byte_err_i,
  input  logic             rx_busy_i,
  output logic             we_o,
  output logic [AW-1:0]    waddr_o,
  output logic [7:0]       wdata_o,
  output logic [AW-1:0]    raddr_o,
  input  logic [7:0]       rdata_i,
  output logic             tx_valid_o,
  output logic [7:0]       tx_data_o,
  input  logic             tx_ready_i
);
  import ubr_pkg::*;
  localparam int unsigned IW = DIV_W + IDLE_SHIFT;

  pstate_e state_q;
  logic is_rd_q, match_q, ack_pend_q;
  logic [AW-1:0] ptr_q;
  logic [7:0] rem_q;
  logic [IW-1:0] idle_q, idle_lim;
  logic in_pkt;

  assign idle_lim = {bit_div_i, {IDLE_SHIFT{1'b0}}};
  assign in_pkt   = state_q inside {P_DEV, P_REG, P_CNT, P_DATA};

  always_comb begin
    we_o       = (state_q == P_DATA) && byte_valid_i && !byte_err_i && match_q;
    waddr_o    = ptr_q;
    wdata_o    = byte_i;
    raddr_o    = ptr_q;
    tx_valid_o = (state_q == P_RESP);
    tx_data_o  = ack_pend_q ? ACK_CODE : rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idle_q <= '0;
    else if (!in_pkt || byte_valid_i || rx_busy_i) idle_q <= '0;
    else if (idle_q < idle_lim) idle_q <= idle_q + IW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= P_SYNC;
      is_rd_q    <= 1'b0;
      match_q    <= 1'b0;
      ack_pend_q <= 1'b0;
      ptr_q      <= '0;
      rem_q      <= '0;
    end else begin
      case (state_q)
        P_SYNC: if (byte_valid_i && !byte_err_i && byte_i == SYNC_CODE) state_q <= P_DEV;
        P_RESP: begin
          if (tx_ready_i) begin
            if (ack_pend_q) begin
              ack_pend_q <= 1'b0;
              if (!is_rd_q) state_q <= P_SYNC;
            end else begin
              ptr_q <= ptr_q + AW'(1);
              rem_q <= rem_q - 8'd1;
              if (rem_q == 8'd1) state_q <= P_SYNC;
            end
          end
        end
        default: begin
          if (byte_valid_i) begin
            if (byte_err_i) state_q <= P_SYNC;
            else begin
              case (state_q)
                P_DEV: begin
                  match_q <= (byte_i[7:1] == dev_addr_i);
                  is_rd_q <= byte_i[0];
                  state_q <= P_REG;
                end
                P_REG: begin
                  ptr_q   <= byte_i[AW-1:0];
                  state_q <= P_CNT;
                end
                P_CNT: begin
                  rem_q      <= (byte_i == 8'd0) ? 8'd1 : byte_i;
                  ack_pend_q <= 1'b1;
                  if (is_rd_q) state_q <= match_q ? P_RESP : P_SYNC;
                  else state_q <= P_DATA;
                end
                default: begin  // P_DATA
                  ptr_q <= ptr_q + AW'(1);
                  rem_q <= rem_q - 8'd1;
                  if (rem_q == 8'd1) state_q <= match_q ? P_RESP : P_SYNC;
                end
              endcase
            end
          end else if (idle_q >= idle_lim) begin
            state_q <= P_SYNC;
          end
        end
      endcase
    end
  end

  AST_ERR_ABORTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && byte_err_i && in_pkt) |=> state_q == P_SYNC); // R7
  AST_IDLE_TIMEOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_pkt && !byte_valid_i && idle_q >= idle_lim) |=> state_q == P_SYNC); // R8
  AST_RESP_ONLY_MATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> match_q); // R3
endmodule

// File: rtl/uart_reg_bridge.sv
`timescale 1ns/1ps
module uart_reg_bridge #(
  parameter int unsigned NREGS = 16,
  parameter int unsigned DIV_W = 16,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  output logic             tx_o,
  input  logic [DIV_W-1:0] bit_div_i,
  input  logic [6:0]       dev_addr_i,
  input  logic             cfg_block_i,
  input  logic [AW-1:0]    reg_raddr_i,
  output logic [7:0]       reg_rdata_o
);
  logic rx_busy, rx_valid, rx_err;
  logic [7:0] rx_data;
  logic we;
  logic [AW-1:0] waddr, raddr;
  logic [7:0] wdata, rdata;
  logic tx_valid, tx_ready;
  logic [7:0] tx_data;

  ubr_rx #(.DIV_W(DIV_W)) u_rx (
    .clk_i, .rst_ni, .rx_i, .bit_div_i,
    .busy_o(rx_busy), .valid_o(rx_valid), .data_o(rx_data), .err_o(rx_err)
  );

  ubr_parser #(.AW(AW), .DIV_W(DIV_W)) u_parser (
    .clk_i, .rst_ni, .bit_div_i, .dev_addr_i,
    .byte_valid_i(rx_valid), .byte_i(rx_data), .byte_err_i(rx_err), .rx_busy_i(rx_busy),
    .we_o(we), .waddr_o(waddr), .wdata_o(wdata), .raddr_o(raddr), .rdata_i(rdata),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready)
  );

  ubr_regs #(.NREGS(NREGS), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .lock_set_i(cfg_block_i),
    .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_a_i(raddr), .rdata_a_o(rdata),
    .raddr_b_i(reg_raddr_i), .rdata_b_o(reg_rdata_o)
  );

  ubr_tx #(.DIV_W(DIV_W)) u_tx (
    .clk_i, .rst_ni, .bit_div_i,
    .valid_i(tx_valid), .data_i(tx_data), .ready_o(tx_ready), .tx_o
  );
endmodule

// File: tb/uart_reg_bridge_tb_top.sv
`timescale 1ns/1ps
module uart_reg_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NREGS = 16;
  localparam logic [6:0] MY_ADDR = 7'h48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_r = 1'b1;
  logic tx;
  logic [15:0] div_r = 16'd10;
  logic cfg_blk = 1'b0;
  logic [3:0] raddr = '0;
  logic [7:0] rdata;

  int cur_div = 10;
  int n_chk = 0, n_err = 0;
  logic [7:0] model [NREGS];
  bit locked = 0;
  logic [7:0] wbuf [8];
  logic [7:0] txlog [1024];
  int txn = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_reg_bridge dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx_r), .tx_o(tx),
    .bit_div_i(div_r), .dev_addr_i(MY_ADDR), .cfg_block_i(cfg_blk),
    .reg_raddr_i(raddr), .reg_rdata_o(rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // serial line monitor for tx_o (R1)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && tx == 1'b0) begin
        logic [7:0] b;
        logic p, s;
        repeat (cur_div/2 - 1) @(negedge clk);
        chk(tx == 1'b0, "R1 start bit", tx, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (cur_div) @(negedge clk);
          b[i] = tx;
        end
        repeat (cur_div) @(negedge clk);
        p = tx;
        repeat (cur_div) @(negedge clk);
        s = tx;
        chk(p == ^b, "R1 parity", p, ^b);
        chk(s == 1'b1, "R1 stop bit", s, 1);
        if (txn < 1024) txlog[txn] = b;
        txn++;
      end
    end
  end

  task automatic send_byte(input logic [7:0] b, input bit bad_par = 0, input bit bad_stop = 0);
    logic [10:0] f;
    f = {~bad_stop, (^b) ^ bad_par, b, 1'b0};
    for (int i = 0; i < 11; i++) begin
      rx_r = f[i];
      repeat (cur_div) @(negedge clk);
    end
    rx_r = 1'b1;
    repeat ($urandom_range(1, 4)) @(negedge clk);
  endtask

  task automatic settle(input int nbytes);
    repeat ((nbytes + 1) * 11 * cur_div + 30) @(negedge clk);
  endtask

  task automatic peek(input int r, output logic [7:0] v);
    raddr = 4'(r);
    #1;
    v = rdata;
  endtask

  task automatic expect_none(input int start, input string req);
    chk(txn == start, req, txn - start, 0);
  endtask

  task automatic do_write(input logic [6:0] a, input int r, input int cnt, input string req);
    int n, st;
    n = (cnt == 0) ? 1 : cnt;
    st = txn;
    send_byte(8'h79);
    send_byte({a, 1'b0});
    send_byte(8'(r));
    send_byte(8'(cnt));
    for (int k = 0; k < n; k++) send_byte(wbuf[k]);
    if (a == MY_ADDR && !locked)
      for (int k = 0; k < n; k++) model[(r + k) % NREGS] = wbuf[k];
    settle(1);
    if (a == MY_ADDR) begin
      chk(txn - st == 1, req, txn - st, 1);
      if (txn - st == 1) chk(txlog[st] == 8'hC3, req, txlog[st], 8'hC3);
    end else expect_none(st, req);
  endtask

  task automatic do_read(input logic [6:0] a, input int r, input int cnt, input string req);
    int n, st;
    n = (cnt == 0) ? 1 : cnt;
    st = txn;
    send_byte(8'h79);
    send_byte({a, 1'b1});
    send_byte(8'(r));
    send_byte(8'(cnt));
    settle(n + 1);
    if (a == MY_ADDR) begin
      chk(txn - st == n + 1, req, txn - st, n + 1);
      if (txn - st == n + 1) begin
        chk(txlog[st] == 8'hC3, req, txlog[st], 8'hC3);
        for (int k = 0; k < n; k++)
          chk(txlog[st + 1 + k] == model[(r + k) % NREGS], req,
              txlog[st + 1 + k], model[(r + k) % NREGS]);
      end
    end else expect_none(st, req);
  endtask

  task automatic check_all_regs(input string req);
    logic [7:0] v;
    for (int r = 0; r < NREGS; r++) begin
      peek(r, v);
      chk(v == model[r], req, v, model[r]);
    end
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int st;
    void'($urandom(32'd20240611));
    for (int r = 0; r < NREGS; r++) model[r] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10 reset state
    chk(tx == 1'b1, "R10 tx idle", tx, 1);
    check_all_regs("R10 reset regs / R11 port");

    // R4 single write, R5 read back
    wbuf[0] = 8'hA5;
    do_write(MY_ADDR, 3, 1, "R4 single write ack");
    peek(3, v); chk(v == 8'hA5, "R11 port after write", v, 8'hA5);
    do_read(MY_ADDR, 3, 1, "R5 single read");

    // R4 wrap around top of file
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    do_write(MY_ADDR, 14, 4, "R4 wrap write");
    check_all_regs("R4 wrap contents");
    do_read(MY_ADDR, 15, 3, "R5 wrap read");

    // R6 count zero
    wbuf[0] = 8'h3C; wbuf[1] = 8'hEE;
    do_write(MY_ADDR, 9, 0, "R6 count0 write");
    check_all_regs("R6 count0 only one reg");
    do_read(MY_ADDR, 9, 0, "R6 count0 read");

    // R3 address mismatch: write and read ignored
    wbuf[0] = 8'h99;
    do_write(7'h49, 3, 1, "R3 mismatch write silent");
    check_all_regs("R3 mismatch no write");
    do_read(7'h49, 3, 2, "R3 mismatch read silent");

    // R2 bad sync
    st = txn;
    send_byte(8'h55); send_byte({MY_ADDR, 1'b0}); send_byte(8'd2);
    send_byte(8'd1); send_byte(8'h5A);
    settle(2);
    expect_none(st, "R2 bad sync silent");
    check_all_regs("R2 bad sync no write");

    // R7 parity error on data byte
    st = txn;
    send_byte(8'h79); send_byte({MY_ADDR, 1'b0}); send_byte(8'd5); send_byte(8'd1);
    send_byte(8'hC7, 1'b1, 1'b0);
    settle(2);
    expect_none(st, "R7 parity abort no ack");
    check_all_regs("R7 parity abort no write");

    // R7 framing error on data byte
    st = txn;
    send_byte(8'h79); send_byte({MY_ADDR, 1'b0}); send_byte(8'd5); send_byte(8'd1);
    send_byte(8'hC8, 1'b0, 1'b1);
    settle(2);
    expect_none(st, "R7 framing abort no ack");
    check_all_regs("R7 framing abort no write");

    // R8 long idle gap abandons packet
    st = txn;
    send_byte(8'h79); send_byte({MY_ADDR, 1'b0}); send_byte(8'd6);
    repeat (20 * cur_div) @(negedge clk);
    send_byte(8'd1); send_byte(8'hAA);
    settle(2);
    expect_none(st, "R8 timeout no ack");
    check_all_regs("R8 timeout no write");

    // R8 gap below limit is tolerated
    st = txn;
    send_byte(8'h79); send_byte({MY_ADDR, 1'b0}); send_byte(8'd6);
    repeat (13 * cur_div) @(negedge clk);
    send_byte(8'd1); send_byte(8'hAB);
    model[6] = 8'hAB;
    settle(1);
    chk(txn - st == 1, "R8 short gap ack", txn - st, 1);
    check_all_regs("R8 short gap write");

    // random traffic
    for (int it = 0; it < 30; it++) begin
      int r, c;
      r = $urandom_range(0, NREGS - 1);
      c = $urandom_range(0, 4);
      if ($urandom_range(0, 2) != 0) begin
        for (int k = 0; k < 8; k++) wbuf[k] = 8'($urandom);
        do_write(MY_ADDR, r, c, "R4 random write");
      end else begin
        do_read(MY_ADDR, r, c, "R5 random read");
      end
    end
    check_all_regs("R11 after random");

    // R1 different bit period (odd divider)
    cur_div = 7;
    div_r = 16'd7;
    repeat (20) @(negedge clk);
    wbuf[0] = 8'h81; wbuf[1] = 8'h7E;
    do_write(MY_ADDR, 12, 2, "R1 div7 write");
    do_read(MY_ADDR, 12, 2, "R1 div7 read");

    // R9 lock
    cfg_blk = 1'b1;
    @(negedge clk);
    cfg_blk = 1'b0;
    locked = 1;
    repeat (5) @(negedge clk);
    wbuf[0] = 8'h01; wbuf[1] = 8'h02;
    do_write(MY_ADDR, 3, 2, "R9 locked write acked");
    check_all_regs("R9 locked contents unchanged");
    do_read(MY_ADDR, 3, 2, "R9 read while locked");

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule